// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block connects a CPU register bus to three 8-bit peripheral ports, called A, B and C. The CPU side has chip select, separate read and write strobes, a 2-bit address and an 8-bit data path. Each port pin appears as three signals: an input level, an output value and an output enable. The pad tri-state buffers sit outside the block. Everything is sampled on one clock, so a strobe that lasts one cycle counts as one access.

One control address takes two kinds of word. A word with bit 7 set chooses the operating mode of the two port groups. Group A covers port A and the upper half of port C. Group B covers port B and the lower half of port C. A word with bit 7 clear forces a single port C line high or low.

Port A can work in plain latched mode, in strobed handshake mode or in bidirectional handshake mode. Port B can work in plain latched mode or in strobed handshake mode. In the handshake modes, fixed port C lines carry the strobe, acknowledge, buffer-flag and interrupt signals. Port C bits that are set by a bit command and sit at a strobe or acknowledge position act as the interrupt enables.

Top module: `par_port_ctrl`

## Requirements
- R1: After reset, every output enable is 0, every output value is 0, and rdata_o is 0 while no read is in progress.
- R2: A control write (address 3) with bit 7 set loads the modes and clears the A, B and C output latches and all handshake flags. The fields are: bits 6:5 group A mode (00 plain, 01 strobed, 1x bidirectional), bit 4 port A direction, bit 3 upper C direction, bit 2 group B strobed, bit 1 port B direction, bit 0 lower C direction. A direction bit of 1 means input.
- R3: A control write with bit 7 clear sets port C latch bit wdata[3:1] to wdata[0]. The other latch bits and the modes do not change.
- R4: In plain mode, a value written to an output port drives its pins and is held until the next write to that port. A read of an output port returns the latch. A read of an input port returns the live pin levels.
- R5: The upper and lower port C halves take their direction independently. A read of port C returns the latch on plain output lines and the pins on plain input lines.
- R6: Addresses 0, 1 and 2 select ports A, B and C. A read of address 3 returns 0, and rdata_o is 0 whenever no read is in progress.
- R7: Strobed input on port A uses these lines: PC4 is the active-low strobe input, PC5 is the buffer-full output and PC3 is the interrupt output. While the strobe is low, the pins are captured and buffer-full is set. The interrupt rises after the strobe returns high, but only if buffer-full is set and latch bit 4 is 1. The interrupt clears when a port A read begins, and buffer-full clears when that read ends. A read returns the captured byte.
- R8: Strobed output uses these lines: for port A, PC7 is the active-low output-buffer-full and PC6 is the active-low acknowledge; for port B, PC1 and PC2. A port write asserts the buffer-full line and clears the interrupt. A low acknowledge releases buffer-full. The interrupt (PC3 for A, PC0 for B) rises after the acknowledge returns high, if the enable bit (latch bit 6 for A, bit 2 for B) is 1.
- R9: When group B is strobed, PC2 is an input, and PC1 and PC0 are driven outputs, whichever direction port B has.
- R10: In bidirectional mode, port A uses PC3 through PC7 for its handshake and drives its pins only while PC6 is low. Strobed input data on PC4 is captured as in R7.
- R11: A port C write leaves the latch bits of handshake lines unchanged, and the handshake outputs keep their values. A port C read returns the handshake outputs at their positions and the pin levels on the handshake inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not reading |
| pa_i | input | 8 | Port A pin levels |
| pa_o | output | 8 | Port A output values |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin levels |
| pb_o | output | 8 | Port B output values |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin levels |
| pc_o | output | 8 | Port C output values |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
The assertions assume the following about the inputs. Read and write are never asserted together. A read holds a stable address for its whole duration. Strobe and acknowledge pins change only between clock edges and never fall during a mode write. The stimulus meets these assumptions in three ways. Every bus access is a single-cycle pulse with a separate read or write strobe, followed by an idle cycle. Each pin change is made half a cycle away from the active edge. Each handshake line is held high except during its own one-cycle low pulse, and that pulse is issued only after the mode write has taken effect.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int DW   = 8;
  localparam int AW   = 2;
  localparam int HALF = DW / 2;

  localparam logic [AW-1:0] ADDR_A   = 2'd0;
  localparam logic [AW-1:0] ADDR_B   = 2'd1;
  localparam logic [AW-1:0] ADDR_C   = 2'd2;
  localparam logic [AW-1:0] ADDR_CTL = 2'd3;

  // port C line positions used by handshakes
  localparam int PC_INTR_B = 0;
  localparam int PC_HS1_B  = 1;
  localparam int PC_HS2_B  = 2;
  localparam int PC_INTR_A = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;

  typedef enum logic [1:0] {
    GM_BASIC = 2'd0,
    GM_STRB  = 2'd1,
    GM_BIDIR = 2'd2
  } gmode_t;

  typedef struct packed {
    gmode_t ga;
    logic   a_in;
    logic   cu_in;
    logic   gb_strb;
    logic   b_in;
    logic   cl_in;
  } cfg_t;

  localparam logic [DW-1:0] CFG_RST = 8'h9B;

  function automatic cfg_t decode_cfg(input logic [DW-1:0] w);
    cfg_t c;
    c.ga      = w[6] ? GM_BIDIR : (w[5] ? GM_STRB : GM_BASIC);
    c.a_in    = w[4];
    c.cu_in   = w[3];
    c.gb_strb = w[2];
    c.b_in    = w[1];
    c.cl_in   = w[0];
    return c;
  endfunction
endpackage

// File: rtl/ppi_hs_in.sv
module ppi_hs_in #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         stb_ni,
  input  logic [W-1:0] data_i,
  input  logic         inte_i,
  input  logic         rd_start_i,
  input  logic         rd_end_i,
  output logic [W-1:0] data_o,
  output logic         ibf_o,
  output logic         intr_o
);
  logic         stb_q;
  logic [W-1:0] lat_q;
  logic         ibf_q, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b1;
      lat_q  <= '0;
      ibf_q  <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      stb_q <= stb_ni;
      if (clr_i || !en_i) begin
        lat_q  <= '0;
        ibf_q  <= 1'b0;
        intr_q <= 1'b0;
      end else begin
        if (!stb_ni) begin
          lat_q <= data_i;
          ibf_q <= 1'b1;
        end else if (rd_end_i) begin
          ibf_q <= 1'b0;
        end
        if (rd_start_i || !inte_i) intr_q <= 1'b0;
        else if (stb_ni && !stb_q && ibf_q) intr_q <= 1'b1;
      end
    end
  end

  assign data_o = lat_q;
  assign ibf_o  = ibf_q;
  assign intr_o = intr_q;
endmodule

// File: rtl/ppi_hs_out.sv
module ppi_hs_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic ack_ni,
  input  logic wr_i,
  input  logic inte_i,
  output logic obf_no,
  output logic intr_o
);
  logic ack_q, obf_q, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b1;
      obf_q  <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      ack_q <= ack_ni;
      if (clr_i || !en_i) begin
        obf_q  <= 1'b0;
        intr_q <= 1'b0;
      end else begin
        if (wr_i) obf_q <= 1'b1;
        else if (!ack_ni) obf_q <= 1'b0;
        if (wr_i || !inte_i) intr_q <= 1'b0;
        else if (ack_ni && !ack_q && !obf_q) intr_q <= 1'b1;
      end
    end
  end

  assign obf_no = ~obf_q;
  assign intr_o = intr_q;
endmodule

// File: rtl/ppi_portc.sv
module ppi_portc
  import ppi_pkg::*;
(
  input  cfg_t          cfg_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] pc_lat_i,
  input  logic          intr_a_i,
  input  logic          ibf_a_i,
  input  logic          obf_na_i,
  input  logic          intr_b_i,
  input  logic          hs1_b_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o,
  output logic [DW-1:0] pc_rd_o,
  output logic [DW-1:0] claim_o
);
  logic [DW-1:0] claim, hs_out, hs_val, plain_out;

  always_comb begin
    claim  = '0;
    hs_out = '0;
    hs_val = '0;
    case (cfg_i.ga)
      GM_STRB: begin
        claim[PC_INTR_A]  = 1'b1;
        hs_out[PC_INTR_A] = 1'b1;
        hs_val[PC_INTR_A] = intr_a_i;
        if (cfg_i.a_in) begin
          claim[PC_STB_A]  = 1'b1;
          claim[PC_IBF_A]  = 1'b1;
          hs_out[PC_IBF_A] = 1'b1;
          hs_val[PC_IBF_A] = ibf_a_i;
        end else begin
          claim[PC_ACK_A]  = 1'b1;
          claim[PC_OBF_A]  = 1'b1;
          hs_out[PC_OBF_A] = 1'b1;
          hs_val[PC_OBF_A] = obf_na_i;
        end
      end
      GM_BIDIR: begin
        claim[PC_INTR_A] = 1'b1;
        claim[PC_STB_A]  = 1'b1;
        claim[PC_IBF_A]  = 1'b1;
        claim[PC_ACK_A]  = 1'b1;
        claim[PC_OBF_A]  = 1'b1;
        hs_out[PC_INTR_A] = 1'b1;
        hs_out[PC_IBF_A]  = 1'b1;
        hs_out[PC_OBF_A]  = 1'b1;
        hs_val[PC_INTR_A] = intr_a_i;
        hs_val[PC_IBF_A]  = ibf_a_i;
        hs_val[PC_OBF_A]  = obf_na_i;
      end
      default: ;
    endcase
    if (cfg_i.gb_strb) begin
      claim[PC_INTR_B]  = 1'b1;
      claim[PC_HS1_B]   = 1'b1;
      claim[PC_HS2_B]   = 1'b1;
      hs_out[PC_INTR_B] = 1'b1;
      hs_out[PC_HS1_B]  = 1'b1;
      hs_val[PC_INTR_B] = intr_b_i;
      hs_val[PC_HS1_B]  = hs1_b_i;
    end
  end

  assign plain_out = ~claim & {{HALF{~cfg_i.cu_in}}, {HALF{~cfg_i.cl_in}}};
  assign pc_o      = (hs_val & hs_out) | (pc_lat_i & ~hs_out);
  assign pc_oe_o   = hs_out | plain_out;
  assign pc_rd_o   = (hs_val & hs_out) | (pc_lat_i & plain_out) | (pc_i & ~(hs_out | plain_out));
  assign claim_o   = claim;
endmodule

// File: rtl/par_port_ctrl.sv
module par_port_ctrl
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  localparam int NP = 2;  // handshake-capable ports: 0 = A, 1 = B

  cfg_t          cfg_q;
  logic [DW-1:0] pa_lat_q, pb_lat_q, pc_lat_q;
  logic          rd_q;
  logic [AW-1:0] rd_addr_q;

  logic acc_wr, acc_rd, ctl_wr, mode_wr, bit_wr, rd_start, rd_end;
  logic a_strb, a_bidir;
  logic [DW-1:0] claim, pc_rd, rd_mux;

  logic          en_in [NP], en_out [NP], stb_n [NP], ack_n [NP];
  logic          inte_in [NP], inte_out [NP], wr_port [NP], rs_port [NP], re_port [NP];
  logic [DW-1:0] pin_in [NP], in_lat [NP];
  logic          ibf [NP], intr_in [NP], obf_n [NP], intr_out [NP];

  assign acc_wr   = cs_i && wr_i;
  assign acc_rd   = cs_i && rd_i;
  assign ctl_wr   = acc_wr && (addr_i == ADDR_CTL);
  assign mode_wr  = ctl_wr && wdata_i[7];
  assign bit_wr   = ctl_wr && !wdata_i[7];
  assign rd_start = acc_rd && !rd_q;
  assign rd_end   = rd_q && !acc_rd;
  assign a_strb   = (cfg_q.ga == GM_STRB);
  assign a_bidir  = (cfg_q.ga == GM_BIDIR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= decode_cfg(CFG_RST);
      pa_lat_q  <= '0;
      pb_lat_q  <= '0;
      pc_lat_q  <= '0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_q <= acc_rd;
      if (acc_rd) rd_addr_q <= addr_i;
      if (mode_wr) begin
        cfg_q    <= decode_cfg(wdata_i);
        pa_lat_q <= '0;
        pb_lat_q <= '0;
        pc_lat_q <= '0;
      end else if (bit_wr) begin
        pc_lat_q[wdata_i[3:1]] <= wdata_i[0];
      end else if (acc_wr) begin
        case (addr_i)
          ADDR_A:  pa_lat_q <= wdata_i;
          ADDR_B:  pb_lat_q <= wdata_i;
          ADDR_C:  pc_lat_q <= (pc_lat_q & claim) | (wdata_i & ~claim);
          default: ;
        endcase
      end
    end
  end

  // per-port handshake wiring
  assign en_in[0]    = (a_strb && cfg_q.a_in) || a_bidir;
  assign en_out[0]   = (a_strb && !cfg_q.a_in) || a_bidir;
  assign en_in[1]    = cfg_q.gb_strb && cfg_q.b_in;
  assign en_out[1]   = cfg_q.gb_strb && !cfg_q.b_in;
  assign stb_n[0]    = pc_i[PC_STB_A];
  assign ack_n[0]    = pc_i[PC_ACK_A];
  assign stb_n[1]    = pc_i[PC_HS2_B];
  assign ack_n[1]    = pc_i[PC_HS2_B];
  assign inte_in[0]  = pc_lat_q[PC_STB_A];
  assign inte_out[0] = pc_lat_q[PC_ACK_A];
  assign inte_in[1]  = pc_lat_q[PC_HS2_B];
  assign inte_out[1] = pc_lat_q[PC_HS2_B];
  assign pin_in[0]   = pa_i;
  assign pin_in[1]   = pb_i;

  for (genvar g = 0; g < NP; g++) begin : g_hs
    assign wr_port[g] = acc_wr && (addr_i == AW'(g));
    assign rs_port[g] = rd_start && (addr_i == AW'(g));
    assign re_port[g] = rd_end && (rd_addr_q == AW'(g));

    ppi_hs_in #(.W(DW)) i_in (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (mode_wr),
      .en_i       (en_in[g]),
      .stb_ni     (stb_n[g]),
      .data_i     (pin_in[g]),
      .inte_i     (inte_in[g]),
      .rd_start_i (rs_port[g]),
      .rd_end_i   (re_port[g]),
      .data_o     (in_lat[g]),
      .ibf_o      (ibf[g]),
      .intr_o     (intr_in[g])
    );

    ppi_hs_out i_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (mode_wr),
      .en_i   (en_out[g]),
      .ack_ni (ack_n[g]),
      .wr_i   (wr_port[g]),
      .inte_i (inte_out[g]),
      .obf_no (obf_n[g]),
      .intr_o (intr_out[g])
    );
  end

  ppi_portc i_portc (
    .cfg_i    (cfg_q),
    .pc_i     (pc_i),
    .pc_lat_i (pc_lat_q),
    .intr_a_i (intr_in[0] | intr_out[0]),
    .ibf_a_i  (ibf[0]),
    .obf_na_i (obf_n[0]),
    .intr_b_i (intr_in[1] | intr_out[1]),
    .hs1_b_i  (cfg_q.b_in ? ibf[1] : obf_n[1]),
    .pc_o     (pc_o),
    .pc_oe_o  (pc_oe_o),
    .pc_rd_o  (pc_rd),
    .claim_o  (claim)
  );

  assign pa_o    = pa_lat_q;
  assign pb_o    = pb_lat_q;
  assign pa_oe_o = a_bidir ? {DW{~pc_i[PC_ACK_A]}} : {DW{~cfg_q.a_in}};
  assign pb_oe_o = {DW{~cfg_q.b_in}};

  always_comb begin
    case (addr_i)
      ADDR_A:  rd_mux = en_in[0] ? in_lat[0] : (cfg_q.a_in ? pa_i : pa_lat_q);
      ADDR_B:  rd_mux = en_in[1] ? in_lat[1] : (cfg_q.b_in ? pb_i : pb_lat_q);
      ADDR_C:  rd_mux = pc_rd;
      default: rd_mux = '0;
    endcase
  end

  assign rdata_o = acc_rd ? rd_mux : '0;
endmodule

// File: rtl/ppi_checker.sv
module ppi_checker
  import ppi_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] pa_o,
  input logic [DW-1:0] pa_oe_o,
  input logic [DW-1:0] pb_o,
  input logic [DW-1:0] pc_i,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] pc_oe_o,
  input cfg_t          cfg_q,
  input logic [DW-1:0] pc_lat_q
);
  logic ctl_cmd, mode_cmd, bit_cmd;
  assign ctl_cmd  = cs_i && wr_i && (addr_i == ADDR_CTL);
  assign mode_cmd = ctl_cmd && wdata_i[7];
  assign bit_cmd  = ctl_cmd && !wdata_i[7];

  assert_mode_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_cmd |=> (pa_o == '0) && (pb_o == '0));

  assert_bit_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cmd |=> (pc_lat_q[$past(wdata_i[3:1])] == $past(wdata_i[0])) && (cfg_q == $past(cfg_q)));

  assert_out_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i) |=> $stable(pa_o) && $stable(pb_o));

  assert_ctl_read_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == ADDR_CTL) || !(cs_i && rd_i) |-> rdata_o == '0);

  assert_ibf_on_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.ga == GM_STRB && cfg_q.a_in && !pc_i[PC_STB_A] && !mode_cmd) |=> pc_o[PC_IBF_A]);

  assert_b_lines_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.gb_strb |-> pc_oe_o[2:0] == 3'b011);

  assert_bidir_float_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.ga == GM_BIDIR && pc_i[PC_ACK_A]) |-> pa_oe_o == '0);
endmodule

bind par_port_ctrl ppi_checker i_ppi_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_i     (cs_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pa_o     (pa_o),
  .pa_oe_o  (pa_oe_o),
  .pb_o     (pb_o),
  .pc_i     (pc_i),
  .pc_o     (pc_o),
  .pc_oe_o  (pc_oe_o),
  .cfg_q    (cfg_q),
  .pc_lat_q (pc_lat_q)
);

// File: tb/test_par_port_ctrl.sv
module test_par_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_o, pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = 8'h54;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  par_port_ctrl i_par_port_ctrl (
    .clk_i (clk), .rst_ni (rst_ni), .cs_i (cs), .rd_i (rd), .wr_i (wr),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata_o),
    .pa_i (pa_i), .pa_o (pa_o), .pa_oe_o (pa_oe_o),
    .pb_i (pb_i), .pb_o (pb_o), .pb_oe_o (pb_oe_o),
    .pc_i (pc_i), .pc_o (pc_o), .pc_oe_o (pc_oe_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data mid-cycle against the scoreboard
  always @(negedge clk) begin
    #5;
    if (cs && rd) begin
      item_t it;
      if (sb_q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R6: unexpected read got %h expected none", rdata_o);
      end else begin
        it = sb_q.pop_front();
        chk(rdata_o, it.exp, it.tag);
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    sb_q.push_back(it);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk(pa_oe_o, 8'h00, "R1 pa_oe");
    chk(pb_oe_o, 8'h00, "R1 pb_oe");
    chk(pc_oe_o, 8'h00, "R1 pc_oe");
    chk(pa_o | pb_o, 8'h00, "R1 outputs");
    chk(rdata_o, 8'h00, "R1 R6 idle rdata");
    pa_i = 8'h5A;
    bus_rd(2'd0, 8'h5A, "R4 live input A");
    bus_rd(2'd3, 8'h00, "R6 control reads zero");

    // plain mode: A out, C upper out, B in, C lower in
    bus_wr(2'd3, 8'h83);
    #1;
    chk(pa_oe_o, 8'hFF, "R2 A output");
    chk(pb_oe_o, 8'h00, "R2 B input");
    chk(pc_oe_o, 8'hF0, "R5 C halves");
    bus_wr(2'd0, 8'h3C);
    #1 chk(pa_o, 8'h3C, "R4 A latched");
    pa_i = 8'hC1;
    bus_rd(2'd0, 8'h3C, "R4 read output latch");
    #1 chk(pa_o, 8'h3C, "R4 A held");
    pb_i = 8'h77;
    bus_rd(2'd1, 8'h77, "R4 live input B");
    pc_i = 8'h03;
    bus_wr(2'd2, 8'hA5);
    #1 chk(pc_o & pc_oe_o, 8'hA0, "R5 upper C driven");
    bus_rd(2'd2, 8'hA3, "R5 C mixed read");
    bus_wr(2'd3, 8'h0E);
    #1 chk(pc_o & pc_oe_o, 8'h20, "R3 clear PC7");
    chk(pa_oe_o, 8'hFF, "R3 mode kept");
    bus_wr(2'd3, 8'h83);
    #1 chk(pa_o, 8'h00, "R2 latch cleared");
    chk(pc_o & pc_oe_o, 8'h00, "R2 C latch cleared");

    // strobed input on A
    pc_i = 8'h54;
    bus_wr(2'd3, 8'hB1);
    #1 chk(pc_oe_o, 8'hE8, "R7 C line roles");
    bus_wr(2'd3, 8'h09);
    #1;
    pa_i = 8'hC3; pc_i = 8'h44;
    step();
    chk(pc_o & 8'h28, 8'h20, "R7 IBF set intr low");
    pc_i = 8'h54; pa_i = 8'h00;
    step();
    chk(pc_o & 8'h28, 8'h28, "R7 intr after strobe");
    bus_rd(2'd2, 8'h3C, "R11 C status read");
    bus_rd(2'd0, 8'hC3, "R7 captured byte");
    step();
    chk(pc_o & 8'h28, 8'h00, "R7 flags cleared by read");
    bus_wr(2'd2, 8'hFF);
    #1 chk(pc_o & 8'hE8, 8'hC0, "R11 claimed lines kept");
    bus_wr(2'd3, 8'h08);
    #1;
    pc_i = 8'h44;
    step();
    pc_i = 8'h54;
    step();
    chk(pc_o & 8'h28, 8'h20, "R7 no intr without enable");

    // strobed output on B
    bus_wr(2'd3, 8'h8D);
    #1 chk(pc_oe_o, 8'h03, "R9 B lines");
    chk(pc_o & 8'h03, 8'h02, "R8 OBF idle");
    bus_wr(2'd3, 8'h05);
    bus_wr(2'd1, 8'h96);
    #1 chk(pb_o, 8'h96, "R8 B data");
    chk(pb_oe_o, 8'hFF, "R8 B driven");
    chk(pc_o & 8'h03, 8'h00, "R8 R9 OBF active");
    pc_i = 8'h50;
    step();
    chk(pc_o & 8'h03, 8'h02, "R8 ack releases OBF");
    pc_i = 8'h54;
    step();
    chk(pc_o & 8'h03, 8'h03, "R8 intr after ack");
    bus_wr(2'd1, 8'h11);
    #1 chk(pc_o & 8'h03, 8'h00, "R8 write clears intr");
    bus_rd(2'd1, 8'h11, "R8 B read latch");

    // bidirectional A
    bus_wr(2'd3, 8'hC3);
    #1 chk(pc_oe_o, 8'hA8, "R10 C line roles");
    chk(pa_oe_o, 8'h00, "R10 A floating");
    bus_wr(2'd3, 8'h0D);
    bus_wr(2'd3, 8'h09);
    bus_wr(2'd0, 8'h5E);
    #1 chk(pc_o & 8'h80, 8'h00, "R10 OBF active");
    pc_i = 8'h14;
    #1 chk(pa_oe_o, 8'hFF, "R10 A driven on ack");
    chk(pa_o, 8'h5E, "R10 A data");
    step();
    chk(pc_o & 8'h80, 8'h80, "R10 OBF released");
    pc_i = 8'h54;
    step();
    chk(pc_o & 8'h08, 8'h08, "R10 intr after ack");
    chk(pa_oe_o, 8'h00, "R10 A floats again");
    pa_i = 8'h81; pc_i = 8'h44;
    step();
    chk(pc_o & 8'h20, 8'h20, "R10 IBF on strobe");
    pc_i = 8'h54; pa_i = 8'h00;
    bus_rd(2'd0, 8'h81, "R10 captured byte");
    step();
    chk(pc_o & 8'h20, 8'h00, "R10 IBF cleared");

    step();
    if (sb_q.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL R6: got %0d pending reads expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule